// File: doc/BRIEF.md
# Multichannel Stream Packet Framing Checker

This block sits at the receiving edge of a streaming datapath. The datapath carries samples from N channels, interleaved, and each group of N consecutive samples forms one packet. Samples arrive on a ready/valid sink that carries a data word, a start flag, an end flag and a 2-bit upstream error field. The block gives every accepted sample its channel index and checks that each packet opens on channel 0 and closes exactly on channel N-1. It classifies any framing fault into a 2-bit code.

Every sample the block keeps is written into a small FIFO, together with its channel index and its error code. The FIFO drains through a ready/valid source. The error code is part of the sample it belongs to, so it appears on the source for that one transfer only. After any fault the controller drops back and waits for the next start flag. The datapath behind it keeps running, and samples already queued still drain.

Top module: `mc_frame_checker`

## Requirements
- R1: A sample is taken from the sink only in a cycle where `in_valid` and `in_ready` are both high. A source sample stays stable while `out_valid` is high and `out_ready` is low, and leaves the FIFO only when both are high.
- R2: A sample with `in_sop` high is given channel 0. Each later sample of the same packet gets the previous channel plus one. `out_chan` always lies in 0..N-1.
- R3: A sample on channel N-1 with `in_eop` high closes the packet with code 00. The next sample must then carry `in_sop`.
- R4: A sample without `in_sop` that arrives while no packet is open, after reset or after a clean close, is forwarded with code 01 (missing start).
- R5: Code 10 (missing end) is given to a sample on channel N-1 that has `in_eop` low, and to a sample with `in_sop` high that arrives while a packet is open. That second sample is forwarded with channel 0.
- R6: Code 11 (unexpected end) is given to a sample with `in_eop` high on a channel below N-1. This includes a sample with both flags high when N > 1.
- R7: A sample whose `in_err` is not 00 is forwarded with that same value as its code, whatever its framing.
- R8: After any nonzero code, samples with `in_sop` low and `in_err` equal to 00 are accepted but discarded, and nothing is forwarded for them. This lasts until a sample with `in_sop` high arrives.
- R9: A code is attached only to the sample that raised it. Every other forwarded sample carries 00.
- R10: `in_ready` is low exactly when the FIFO holds FIFO_DEPTH entries. `out_valid` is high exactly when the FIFO is not empty. The FIFO keeps draining while `in_valid` is low.
- R11: While `rst_n` is low at a rising clock edge, the FIFO empties and the controller returns to its no-packet state. After that edge, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Sink sample present |
| in_ready | output | 1 | Sink can take a sample this cycle |
| in_data | input | DATA_W | Sink sample word |
| in_sop | input | 1 | Sample opens a packet |
| in_eop | input | 1 | Sample closes a packet |
| in_err | input | 2 | Upstream error field, 00 means clean |
| out_valid | output | 1 | Source sample present |
| out_ready | input | 1 | Downstream takes the source sample |
| out_data | output | DATA_W | Source sample word |
| out_chan | output | CH_W | Channel index of the source sample |
| out_err | output | 2 | Code: 00 clean, 01 missing start, 10 missing end, 11 unexpected end |

## Verification
Some properties are checked on every cycle by the bound checker: a stalled source sample holds its value, a start sample is written as channel 0, a nonzero upstream field is written unchanged, discarded samples cause no FIFO write, a clean close on the last channel carries code 00, and the fill level never passes the depth. Other behaviour depends on a history of several samples, so only the bench scenarios can show it. This covers the order of the channel indices across whole packets, the choice between codes 01, 10 and 11 after a given run of flags, the exact number of samples discarded while the controller waits for a start flag, and the FIFO refilling and draining under backpressure and reset.

// File: rtl/mcfc_pkg.sv
package mcfc_pkg;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'b00,
        ERR_NO_SOP  = 2'b01,
        ERR_NO_EOP  = 2'b10,
        ERR_BAD_EOP = 2'b11
    } frame_err_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESYNC = 2'd1,
        ST_BODY   = 2'd2
    } frame_st_e;

    typedef struct packed {
        logic       keep;
        frame_err_e code;
        frame_st_e  next_st;
    } verdict_t;

    function automatic int unsigned width_for(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Decide what to do with one accepted sample.
    function automatic verdict_t judge(
        input frame_st_e  st,
        input logic       sop,
        input logic       eop,
        input logic [1:0] err_in,
        input logic       at_last
    );
        verdict_t v;
        v.keep    = 1'b1;
        v.code    = ERR_NONE;
        v.next_st = ST_RESYNC;
        if (err_in != 2'b00) begin
            v.code = frame_err_e'(err_in);
        end else if (st == ST_BODY && sop) begin
            v.code = ERR_NO_EOP;
        end else if (!sop && st != ST_BODY) begin
            if (st == ST_IDLE) v.code = ERR_NO_SOP;
            else               v.keep = 1'b0;
        end else if (at_last) begin
            if (eop) v.next_st = ST_IDLE;
            else     v.code    = ERR_NO_EOP;
        end else begin
            if (eop) v.code    = ERR_BAD_EOP;
            else     v.next_st = ST_BODY;
        end
        return v;
    endfunction

endpackage

// File: rtl/mcfc_frame_ctrl.sv
module mcfc_frame_ctrl
    import mcfc_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            sop,
    input  logic            eop,
    input  logic [1:0]      err_in,
    output logic            keep,
    output logic [CH_W-1:0] chan,
    output logic [1:0]      code,
    output frame_st_e       state
);

    localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

    frame_st_e       st_q;
    logic [CH_W-1:0] chan_q;
    logic [CH_W-1:0] cur_chan;
    logic            at_last;
    verdict_t        v;

    always_comb begin
        cur_chan = (sop || st_q != ST_BODY) ? '0 : chan_q;
        at_last  = (cur_chan == LAST_CH);
        v        = judge(st_q, sop, eop, err_in, at_last);
    end

    assign keep  = v.keep;
    assign code  = v.code;
    assign chan  = cur_chan;
    assign state = st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            chan_q <= '0;
        end else if (take) begin
            st_q   <= v.next_st;
            chan_q <= (v.next_st == ST_BODY) ? cur_chan + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/mcfc_fifo.sv
module mcfc_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    parameter int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    fill
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [CW-1:0]    cnt;
    logic             do_push;
    logic             do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign fill    = cnt;
    assign rdata   = mem[rd_ptr];
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/mc_frame_checker.sv
module mc_frame_checker
    import mcfc_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned CH_W       = width_for(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [1:0]        in_err,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_chan,
    output logic [1:0]        out_err
);

    localparam int unsigned ENT_W  = DATA_W + CH_W + 2;
    localparam int unsigned FILL_W = $clog2(FIFO_DEPTH + 1);

    logic              accept;
    logic              keep;
    logic              wr_en;
    logic [CH_W-1:0]   wr_chan;
    logic [1:0]        wr_err;
    frame_st_e         ctrl_state;
    logic [ENT_W-1:0]  wr_word;
    logic [ENT_W-1:0]  rd_word;
    logic              fifo_full;
    logic              fifo_empty;
    logic [FILL_W-1:0] fill;

    assign accept = in_valid && in_ready;
    assign wr_en  = accept && keep;

    mcfc_frame_ctrl #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .take   (accept),
        .sop    (in_sop),
        .eop    (in_eop),
        .err_in (in_err),
        .keep   (keep),
        .chan   (wr_chan),
        .code   (wr_err),
        .state  (ctrl_state)
    );

    assign wr_word = {in_data, wr_chan, wr_err};

    mcfc_fifo #(
        .WIDTH (ENT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (wr_en),
        .wdata (wr_word),
        .pop   (out_ready),
        .rdata (rd_word),
        .full  (fifo_full),
        .empty (fifo_empty),
        .fill  (fill)
    );

    assign in_ready  = !fifo_full;
    assign out_valid = !fifo_empty;
    assign out_data  = rd_word[ENT_W-1 -: DATA_W];
    assign out_chan  = rd_word[2 +: CH_W];
    assign out_err   = rd_word[1:0];

endmodule

// File: rtl/mcfc_checker.sv
module mcfc_checker
    import mcfc_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned NUM_CH     = 4,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned CH_W       = 2,
    parameter int unsigned FILL_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sop,
    input logic              in_eop,
    input logic [1:0]        in_err,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic [CH_W-1:0]   out_chan,
    input logic [1:0]        out_err,
    input logic              wr_en,
    input logic [CH_W-1:0]   wr_chan,
    input logic [1:0]        wr_err,
    input frame_st_e         ctrl_state,
    input logic [FILL_W-1:0] fill
);

    logic take;
    assign take = in_valid && in_ready;

    p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_chan) && $stable(out_err)));

    p_sop_chan0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_sop) |-> (wr_en && wr_chan == '0));

    p_chan_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_chan <= CH_W'(NUM_CH - 1)));

    p_clean_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_err == 2'b00 && in_eop && !in_sop && ctrl_state == ST_BODY
         && wr_chan == CH_W'(NUM_CH - 1)) |-> (wr_en && wr_err == 2'b00));

    p_err_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_err != 2'b00) |-> (wr_en && wr_err == in_err));

    p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ctrl_state == ST_RESYNC && !in_sop && in_err == 2'b00) |-> !wr_en);

    p_ready_after_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && out_valid && out_ready) |=> in_ready);

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FILL_W'(FIFO_DEPTH));

endmodule

bind mc_frame_checker mcfc_checker #(
    .DATA_W     (DATA_W),
    .NUM_CH     (NUM_CH),
    .FIFO_DEPTH (FIFO_DEPTH),
    .CH_W       (CH_W),
    .FILL_W     (FILL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_sop     (in_sop),
    .in_eop     (in_eop),
    .in_err     (in_err),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_chan   (out_chan),
    .out_err    (out_err),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_err     (wr_err),
    .ctrl_state (ctrl_state),
    .fill       (fill)
);

// File: tb/mc_frame_checker_tb_top.sv
module mc_frame_checker_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 8;
    localparam int NCH   = 3;
    localparam int DEPTH = 4;
    localparam int CW    = 2;
    localparam int EW    = DW + CW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_data = '0;
    logic          in_sop = 1'b0;
    logic          in_eop = 1'b0;
    logic [1:0]    in_err = 2'b00;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [DW-1:0] out_data;
    logic [CW-1:0] out_chan;
    logic [1:0]    out_err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mc_frame_checker #(
        .DATA_W     (DW),
        .NUM_CH     (NCH),
        .FIFO_DEPTH (DEPTH)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_sop    (in_sop),
        .in_eop    (in_eop),
        .in_err    (in_err),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_chan  (out_chan),
        .out_err   (out_err)
    );

    // behavioural reference: queue of expected source words, packet state
    logic [EW-1:0] q[$];
    int  mst = 0;      // 0 no packet, 1 waiting for start, 2 inside packet
    int  mch = 0;
    int  n_checks = 0;
    int  n_errors = 0;
    int  n_pops = 0;
    int  n_takes = 0;
    bit  finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // One cycle: drive inputs, compare outputs with model, advance model.
    task automatic step(input logic v, input logic [DW-1:0] d, input logic s,
                        input logic e, input logic [1:0] er, input logic ordy);
        logic [EW-1:0] head;
        bit exp_ready, exp_valid;
        int ch, code, nst;
        bit keep;
        in_valid = v; in_data = d; in_sop = s; in_eop = e; in_err = er;
        out_ready = ordy;
        #1;
        exp_ready = (q.size() < DEPTH);
        exp_valid = (q.size() > 0);
        if (rst_n) begin
            chk(in_ready === exp_ready, "R10 in_ready", longint'(in_ready), longint'(exp_ready));
            chk(out_valid === exp_valid, "R10 out_valid", longint'(out_valid), longint'(exp_valid));
            if (exp_valid) begin
                head = q[0];
                chk(out_data === head[EW-1 -: DW], "R1 out_data",
                    longint'(out_data), longint'(head[EW-1 -: DW]));
                chk(out_chan === head[2 +: CW], "R2 out_chan",
                    longint'(out_chan), longint'(head[2 +: CW]));
                chk(out_err === head[1:0], "R4 R5 R6 R7 R9 out_err",
                    longint'(out_err), longint'(head[1:0]));
            end
        end
        if (!rst_n) begin
            q.delete(); mst = 0; mch = 0;
        end else begin
            if (exp_valid && ordy) begin
                void'(q.pop_front());
                n_pops++;
            end
            if (v && exp_ready) begin
                n_takes++;
                ch = (s || mst != 2) ? 0 : mch;
                keep = 1'b1; code = 0; nst = 1;
                if (er != 2'b00)             code = int'(er);
                else if (mst == 2 && s)      code = 2;
                else if (!s && mst != 2) begin
                    if (mst == 0) code = 1; else keep = 1'b0;
                end else if (ch == NCH - 1) begin
                    if (e) nst = 0; else code = 2;
                end else begin
                    if (e) code = 3; else nst = 2;
                end
                if (keep) q.push_back({d, CW'(ch), code[1:0]});
                mst = nst;
                mch = (nst == 2) ? ch + 1 : 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input logic ordy);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0, 1'b0, 2'b00, ordy);
    endtask

    task automatic good_pkt(input logic [DW-1:0] base, input logic ordy);
        for (int i = 0; i < NCH; i++)
            step(1'b1, base + DW'(i), i == 0, i == NCH - 1, 2'b00, ordy);
    endtask

    initial begin
        int p0, t0;
        @(negedge clk);
        rst_n = 1'b0;
        idle(3, 1'b1);
        rst_n = 1'b1;
        #1;
        // R11: reset state
        chk(out_valid === 1'b0, "R11 out_valid after reset", longint'(out_valid), 0);
        chk(in_ready === 1'b1, "R11 in_ready after reset", longint'(in_ready), 1);
        @(negedge clk);

        // R2 R3: clean packets back to back
        good_pkt(8'h10, 1'b1);
        good_pkt(8'h20, 1'b1);
        idle(4, 1'b1);

        // R4: sample without start while no packet is open, then R8 discards
        step(1'b1, 8'h30, 1'b0, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h31, 1'b0, 1'b0, 2'b00, 1'b1);
        good_pkt(8'h38, 1'b1);

        // R5: last channel without end; start inside open packet
        step(1'b1, 8'h40, 1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h41, 1'b0, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h42, 1'b0, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h50, 1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h51, 1'b1, 1'b0, 2'b00, 1'b1);
        idle(2, 1'b1);

        // R6: end on channel 1; both flags on one sample
        step(1'b1, 8'h60, 1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h61, 1'b0, 1'b1, 2'b00, 1'b1);
        step(1'b1, 8'h62, 1'b1, 1'b1, 2'b00, 1'b1);
        good_pkt(8'h68, 1'b1);
        idle(4, 1'b1);

        // R7 R8: upstream error mid packet, then three discarded samples
        p0 = n_pops;
        step(1'b1, 8'h70, 1'b1, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h71, 1'b0, 1'b0, 2'b10, 1'b1);
        step(1'b1, 8'h72, 1'b0, 1'b0, 2'b00, 1'b1);
        step(1'b1, 8'h73, 1'b0, 1'b1, 2'b00, 1'b1);
        step(1'b1, 8'h74, 1'b0, 1'b0, 2'b00, 1'b1);
        idle(6, 1'b1);
        chk(n_pops - p0 == 2, "R8 forwarded count after error", n_pops - p0, 2);
        good_pkt(8'h78, 1'b1);
        idle(4, 1'b1);

        // R1 R10: backpressure; input held while full
        t0 = n_takes;
        for (int i = 0; i < 8; i++)
            step(1'b1, 8'h80 + DW'(i), (i % NCH) == 0, (i % NCH) == NCH - 1, 2'b00, 1'b0);
        chk(n_takes - t0 == DEPTH, "R1 samples taken while stalled", n_takes - t0, DEPTH);
        #1;
        chk(in_ready === 1'b0, "R10 ready low when full", longint'(in_ready), 0);
        @(negedge clk);
        p0 = n_pops;
        idle(DEPTH + 2, 1'b1);
        chk(n_pops - p0 == DEPTH, "R10 drain with sink idle", n_pops - p0, DEPTH);
        idle(2, 1'b1);

        // R11: reset with data queued
        good_pkt(8'h90, 1'b0);
        rst_n = 1'b0;
        idle(2, 1'b0);
        rst_n = 1'b1;
        #1;
        chk(out_valid === 1'b0, "R11 out_valid after mid reset", longint'(out_valid), 0);
        chk(in_ready === 1'b1, "R11 in_ready after mid reset", longint'(in_ready), 1);
        @(negedge clk);

        // mixed random traffic; R9 follows from per-cycle code comparison
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] er;
            er = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(1, 3)) : 2'b00;
            step($urandom_range(0, 3) != 0, DW'($urandom),
                 $urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, er,
                 $urandom_range(0, 3) != 0);
        end
        idle(DEPTH + 2, 1'b1);
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

endmodule